// File: doc/BRIEF.md
# Key-Guarded Register Write Gate

This block sits between a 32-bit register bus and a peripheral's register file and decides, for every bus access, whether it reaches the registers. Reads always go through. Writes to the guarded part of the address map are dropped until software has opened the gate. To open it, software writes one magic word to a first key register and then a second magic word to a second key register. Any other value written to either key, including zero, closes the gate again.

The key registers belong to the gate itself. They are never forwarded downstream and they read back as zero. Writes that are forwarded carry their address, data and byte strobes unchanged. They also carry a per-bit write mask expanded from the strobes. In that mask, one designated control bit is kept clear unless the write covers the whole word, so the register file cannot change that bit through a byte or half-word write. A status output shows whether the gate is currently closed.

Top module: `wp_gate`

## Requirements
- R1: After the active-low asynchronous reset, `locked_o` is 1 and a write to a guarded offset is not forwarded.
- R2: A full-word write (`bus_be_i`=4'hF) of 0x83E70B13 to offset 0x6C, followed later by a full-word write of 0x95A4F1E0 to offset 0x70, clears `locked_o` from the cycle after the second write. Accesses to other offsets may come between the two key writes.
- R3: A write of 0 to either key offset sets `locked_o` from the next cycle.
- R4: Any of the following leaves or returns the gate locked: a write to a key offset with a wrong value, a write to a key offset with partial strobes, or the second key written while the first key has not been accepted.
- R5: While locked, a write to a guarded offset (any word below 0x80 other than the two keys) drives `dn_req_o`=0 and `dn_we_o`=0.
- R6: A write to an offset at or above 0x80 is forwarded whatever the lock state.
- R7: A read of any non-key offset is forwarded in the same cycle (`dn_req_o`=1, `dn_we_o`=0) whatever the lock state, and `bus_rdata_o` equals `dn_rdata_i`.
- R8: An access to a key offset is never forwarded, and a read of a key offset returns 0.
- R9: A forwarded write presents `bus_addr_i`, `bus_wdata_i` and `bus_be_i` unchanged. `dn_wmask_o` bit n equals strobe bit n/8. When no write is forwarded, `dn_wmask_o` is 0.
- R10: For a write to offset 0x48, `dn_wmask_o` bit 4 is 1 only if `bus_be_i`=4'hF.
- R11: Writing the first key word again while the gate is open re-arms it. The gate stays locked until the second key word is written again.
- R12: Offsets are decoded on word address bits [7:2]. Bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte strobes |
| bus_rdata_o | output | 32 | Read data back to the bus |
| dn_req_o | output | 1 | Access forwarded to the register file |
| dn_we_o | output | 1 | Forwarded access is a write |
| dn_addr_o | output | 8 | Forwarded offset |
| dn_wdata_o | output | 32 | Forwarded write data |
| dn_be_o | output | 4 | Forwarded byte strobes |
| dn_wmask_o | output | 32 | Per-bit write enable for the register file |
| dn_rdata_i | input | 32 | Read data from the register file |
| locked_o | output | 1 | 1 while guarded writes are blocked |

## Verification
Directed sequences walk the key protocol along the following paths:
- the correct order, which opens the gate;
- the reversed order, a single wrong word, partial strobes on a key write, and zero written to each key, all of which must leave or return the gate locked;
- a repeated first key while open, which re-arms the gate without opening it.

Random traffic weighted toward the two keys, the full-word-only register, guarded offsets and open offsets mixes magic words, zero and random data with random strobes. A bench model of the lock state predicts every forward/drop decision, mask and read value. This separates errors in the drop decision from errors in the key sequencing and from errors in mask shaping.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;
  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  typedef struct packed {
    logic key0;
    logic key1;
    logic prot;
    logic fw_reg;
  } dec_t;
endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode
  import wp_gate_pkg::*;
#(
  parameter int unsigned    AW         = 8,
  parameter logic [AW-1:0]  KEY0_OFF   = 'h6C,
  parameter logic [AW-1:0]  KEY1_OFF   = 'h70,
  parameter logic [AW-1:0]  OPEN_BASE  = 'h80,
  parameter logic [AW-1:0]  FW_REG_OFF = 'h48
) (
  input  logic [AW-3:0] word_i,
  output dec_t          dec_o
);
  localparam logic [AW-3:0] K0W = KEY0_OFF[AW-1:2];
  localparam logic [AW-3:0] K1W = KEY1_OFF[AW-1:2];
  localparam logic [AW-3:0] OBW = OPEN_BASE[AW-1:2];
  localparam logic [AW-3:0] FWW = FW_REG_OFF[AW-1:2];

  always_comb begin
    dec_o.key0   = (word_i == K0W);
    dec_o.key1   = (word_i == K1W);
    dec_o.prot   = (word_i < OBW) && !dec_o.key0 && !dec_o.key1;
    dec_o.fw_reg = (word_i == FWW);
  end
endmodule

// File: rtl/wp_lock_fsm.sv
module wp_lock_fsm
  import wp_gate_pkg::*;
#(
  parameter int unsigned   DW       = 32,
  parameter logic [DW-1:0] KEY0_VAL = 32'h83E7_0B13,
  parameter logic [DW-1:0] KEY1_VAL = 32'h95A4_F1E0,
  localparam int unsigned  BW       = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  dec_t          dec_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] be_i,
  output logic          locked_o
);
  lock_state_e st_q, st_d;
  logic        full;

  assign full = &be_i;

  always_comb begin
    st_d = st_q;
    if (wr_i && dec_i.key0) begin
      st_d = (full && wdata_i == KEY0_VAL) ? LK_ARMED : LK_LOCKED;
    end else if (wr_i && dec_i.key1) begin
      // second key counts only after an accepted first key
      st_d = (full && wdata_i == KEY1_VAL && st_q != LK_LOCKED) ? LK_OPEN : LK_LOCKED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LK_LOCKED;
    else         st_q <= st_d;
  end

  assign locked_o = (st_q != LK_OPEN);
endmodule

// File: rtl/wp_wmask.sv
module wp_wmask #(
  parameter int unsigned DW     = 32,
  parameter int unsigned FW_BIT = 4,
  localparam int unsigned BW    = DW / 8
) (
  input  logic [BW-1:0] be_i,
  input  logic          fw_reg_i,
  input  logic          en_i,
  output logic [DW-1:0] wmask_o
);
  logic [DW-1:0] raw;

  for (genvar b = 0; b < BW; b++) begin : g_byte
    assign raw[b*8 +: 8] = {8{be_i[b]}};
  end

  always_comb begin
    wmask_o = raw;
    if (fw_reg_i && !(&be_i)) wmask_o[FW_BIT] = 1'b0;
    if (!en_i) wmask_o = '0;
  end
endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import wp_gate_pkg::*;
#(
  parameter int unsigned   AW         = 8,
  parameter int unsigned   DW         = 32,
  parameter logic [AW-1:0] KEY0_OFF   = 'h6C,
  parameter logic [AW-1:0] KEY1_OFF   = 'h70,
  parameter logic [AW-1:0] OPEN_BASE  = 'h80,
  parameter logic [AW-1:0] FW_REG_OFF = 'h48,
  parameter int unsigned   FW_BIT     = 4,
  parameter logic [DW-1:0] KEY0_VAL   = 32'h83E7_0B13,
  parameter logic [DW-1:0] KEY1_VAL   = 32'h95A4_F1E0,
  localparam int unsigned  BW         = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic [BW-1:0] bus_be_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          dn_req_o,
  output logic          dn_we_o,
  output logic [AW-1:0] dn_addr_o,
  output logic [DW-1:0] dn_wdata_o,
  output logic [BW-1:0] dn_be_o,
  output logic [DW-1:0] dn_wmask_o,
  input  logic [DW-1:0] dn_rdata_i,
  output logic          locked_o
);
  dec_t dec;
  logic wr, rd, key_hit, wr_ok, rd_ok;

  wp_addr_decode #(
    .AW(AW), .KEY0_OFF(KEY0_OFF), .KEY1_OFF(KEY1_OFF),
    .OPEN_BASE(OPEN_BASE), .FW_REG_OFF(FW_REG_OFF)
  ) u_dec (
    .word_i (bus_addr_i[AW-1:2]),
    .dec_o  (dec)
  );

  assign wr      = bus_req_i & bus_we_i;
  assign rd      = bus_req_i & ~bus_we_i;
  assign key_hit = dec.key0 | dec.key1;

  wp_lock_fsm #(
    .DW(DW), .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .dec_i    (dec),
    .wdata_i  (bus_wdata_i),
    .be_i     (bus_be_i),
    .locked_o (locked_o)
  );

  assign wr_ok = wr & ~key_hit & (~dec.prot | ~locked_o);
  assign rd_ok = rd & ~key_hit;

  wp_wmask #(.DW(DW), .FW_BIT(FW_BIT)) u_mask (
    .be_i     (bus_be_i),
    .fw_reg_i (dec.fw_reg),
    .en_i     (wr_ok),
    .wmask_o  (dn_wmask_o)
  );

  assign dn_req_o    = wr_ok | rd_ok;
  assign dn_we_o     = wr_ok;
  assign dn_addr_o   = bus_addr_i;
  assign dn_wdata_o  = bus_wdata_i;
  assign dn_be_o     = bus_be_i;
  assign bus_rdata_o = rd_ok ? dn_rdata_i : '0;
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk #(
  parameter int unsigned   AW         = 8,
  parameter int unsigned   DW         = 32,
  parameter logic [AW-1:0] KEY0_OFF   = 'h6C,
  parameter logic [AW-1:0] KEY1_OFF   = 'h70,
  parameter logic [AW-1:0] OPEN_BASE  = 'h80,
  parameter logic [AW-1:0] FW_REG_OFF = 'h48,
  parameter int unsigned   FW_BIT     = 4,
  parameter logic [DW-1:0] KEY1_VAL   = 32'h95A4_F1E0,
  localparam int unsigned  BW         = DW / 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_i,
  input logic          bus_we_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic [BW-1:0] bus_be_i,
  input logic [DW-1:0] bus_rdata_o,
  input logic          dn_req_o,
  input logic          dn_we_o,
  input logic [AW-1:0] dn_addr_o,
  input logic [DW-1:0] dn_wdata_o,
  input logic [BW-1:0] dn_be_o,
  input logic [DW-1:0] dn_wmask_o,
  input logic [DW-1:0] dn_rdata_i,
  input logic          locked_o
);
  logic k0, k1, khit, prot, wr, rd;
  assign k0   = bus_addr_i[AW-1:2] == KEY0_OFF[AW-1:2];
  assign k1   = bus_addr_i[AW-1:2] == KEY1_OFF[AW-1:2];
  assign khit = k0 | k1;
  assign prot = (bus_addr_i[AW-1:2] < OPEN_BASE[AW-1:2]) && !khit;
  assign wr   = bus_req_i && bus_we_i;
  assign rd   = bus_req_i && !bus_we_i;

  p_drop_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && locked_o && prot) |-> (!dn_req_o && !dn_we_o));

  p_open_fwd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i >= OPEN_BASE) |-> dn_we_o);

  p_read_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !khit) |-> (dn_req_o && !dn_we_o && bus_rdata_o == dn_rdata_i));

  p_key_hidden_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && khit) |-> (!dn_req_o && bus_rdata_o == '0));

  p_zero_locks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && khit && bus_wdata_i == '0) |=> locked_o);

  p_unlock_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(wr && k1 && (&bus_be_i) && bus_wdata_i == KEY1_VAL));

  p_fields_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_we_o |-> (dn_addr_o == bus_addr_i && dn_wdata_o == bus_wdata_i && dn_be_o == bus_be_i));

  p_idle_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dn_we_o |-> (dn_wmask_o == '0));

  p_fw_bit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_we_o && bus_addr_i[AW-1:2] == FW_REG_OFF[AW-1:2] && !(&bus_be_i)) |-> !dn_wmask_o[FW_BIT]);
endmodule

bind wp_gate wp_gate_chk #(
  .AW(AW), .DW(DW), .KEY0_OFF(KEY0_OFF), .KEY1_OFF(KEY1_OFF),
  .OPEN_BASE(OPEN_BASE), .FW_REG_OFF(FW_REG_OFF), .FW_BIT(FW_BIT), .KEY1_VAL(KEY1_VAL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_be_i(bus_be_i),
  .bus_rdata_o(bus_rdata_o), .dn_req_o(dn_req_o), .dn_we_o(dn_we_o),
  .dn_addr_o(dn_addr_o), .dn_wdata_o(dn_wdata_o), .dn_be_o(dn_be_o),
  .dn_wmask_o(dn_wmask_o), .dn_rdata_i(dn_rdata_i), .locked_o(locked_o)
);

// File: tb/wp_gate_test.sv
module wp_gate_test;
  localparam logic [31:0] K0 = 32'h83E7_0B13;
  localparam logic [31:0] K1 = 32'h95A4_F1E0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [3:0]  bus_be_i = '0;
  logic [31:0] bus_rdata_o, dn_wdata_o, dn_wmask_o;
  logic [31:0] dn_rdata_i = '0;
  logic        dn_req_o, dn_we_o, locked_o;
  logic [7:0]  dn_addr_o;
  logic [3:0]  dn_be_o;

  int n_chk = 0, n_bad = 0;
  int mstate = 0;  // 0 locked, 1 armed, 2 open
  bit done = 0;

  always #4 clk = ~clk;

  wp_gate uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_be_i(bus_be_i),
    .bus_rdata_o(bus_rdata_o), .dn_req_o(dn_req_o), .dn_we_o(dn_we_o),
    .dn_addr_o(dn_addr_o), .dn_wdata_o(dn_wdata_o), .dn_be_o(dn_be_o),
    .dn_wmask_o(dn_wmask_o), .dn_rdata_i(dn_rdata_i), .locked_o(locked_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_k0(input logic [7:0] a); return a[7:2] == 6'h1B; endfunction
  function automatic bit is_k1(input logic [7:0] a); return a[7:2] == 6'h1C; endfunction
  function automatic bit is_prot(input logic [7:0] a); return a < 8'h80 && !is_k0(a) && !is_k1(a); endfunction

  function automatic logic [31:0] exp_mask(input logic [7:0] a, input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    if (a[7:2] == 6'h12 && be != 4'hF) m[4] = 1'b0;
    return m;
  endfunction

  // one bus access; checks combinational outputs before the edge, then updates the model
  task automatic xact(input string tag, input bit we, input logic [7:0] a,
                      input logic [31:0] d, input logic [3:0] be);
    bit key, wok, rok;
    logic [31:0] rdv;
    @(negedge clk);
    rdv = $urandom;
    bus_req_i = 1'b1; bus_we_i = we; bus_addr_i = a; bus_wdata_i = d; bus_be_i = be;
    dn_rdata_i = rdv;
    #2;
    key = is_k0(a) || is_k1(a);
    wok = we && !key && (!is_prot(a) || mstate == 2);
    rok = !we && !key;
    chk(tag, "locked_o", {31'd0, locked_o}, {31'd0, mstate != 2});
    chk(tag, "dn_req_o", {31'd0, dn_req_o}, {31'd0, wok || rok});
    chk(tag, "dn_we_o", {31'd0, dn_we_o}, {31'd0, wok});
    chk(tag, "dn_wmask_o", dn_wmask_o, wok ? exp_mask(a, be) : 32'h0);
    chk(tag, "bus_rdata_o", bus_rdata_o, rok ? rdv : 32'h0);
    if (wok) begin
      chk("R9", "dn_addr_o", {24'd0, dn_addr_o}, {24'd0, a});
      chk("R9", "dn_wdata_o", dn_wdata_o, d);
      chk("R9", "dn_be_o", {28'd0, dn_be_o}, {28'd0, be});
    end
    if (we && is_k0(a)) mstate = (be == 4'hF && d == K0) ? 1 : 0;
    else if (we && is_k1(a)) mstate = (be == 4'hF && d == K1 && mstate != 0) ? 2 : 0;
  endtask

  task automatic idle_chk_lock(input string tag, input bit exp_locked);
    @(negedge clk);
    bus_req_i = 1'b0;
    #2;
    chk(tag, "locked_o", {31'd0, locked_o}, {31'd0, exp_locked});
    chk(tag, "dn_req_o idle", {31'd0, dn_req_o}, 32'd0);
  endtask

  task automatic unlock();
    xact("R2", 1, 8'h6C, K0, 4'hF);
    xact("R2", 1, 8'h70, K1, 4'hF);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk("R1", "locked_o in reset", {31'd0, locked_o}, 32'd1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    idle_chk_lock("R1", 1);
    xact("R1", 1, 8'h10, 32'hDEAD_BEEF, 4'hF);        // dropped
    xact("R5", 1, 8'h48, 32'hFFFF_FFFF, 4'hF);
    xact("R8", 0, 8'h6C, 0, 4'hF);
    xact("R8", 0, 8'h70, 0, 4'hF);
    xact("R7", 0, 8'h04, 0, 4'hF);
    xact("R6", 1, 8'h80, 32'h1234_5678, 4'h3);

    // correct order with an unrelated access in between
    xact("R2", 1, 8'h6C, K0, 4'hF);
    xact("R2", 0, 8'h08, 0, 4'hF);
    xact("R2", 1, 8'h70, K1, 4'hF);
    idle_chk_lock("R2", 0);
    xact("R2", 1, 8'h10, 32'hCAFE_F00D, 4'hF);        // forwarded
    xact("R10", 1, 8'h48, 32'h0000_0010, 4'hF);
    xact("R10", 1, 8'h48, 32'h0000_0010, 4'h1);
    xact("R10", 1, 8'h4A, 32'h0000_0010, 4'h7);        // R12 low bits ignored
    xact("R3", 1, 8'h70, 0, 4'hF);
    idle_chk_lock("R3", 1);
    unlock();
    xact("R3", 1, 8'h6C, 0, 4'hF);
    idle_chk_lock("R3", 1);

    xact("R4", 1, 8'h70, K1, 4'hF);                     // second alone
    idle_chk_lock("R4", 1);
    xact("R4", 1, 8'h70, K1, 4'hF);                     // reversed order
    xact("R4", 1, 8'h6C, K0, 4'hF);
    idle_chk_lock("R4", 1);
    xact("R4", 1, 8'h70, K1 ^ 32'h1, 4'hF);            // wrong second word
    idle_chk_lock("R4", 1);
    xact("R4", 1, 8'h6C, K0, 4'h7);                     // partial strobes
    xact("R4", 1, 8'h70, K1, 4'hF);
    idle_chk_lock("R4", 1);
    xact("R4", 1, 8'h6C, K0 ^ 32'h100, 4'hF);
    xact("R4", 1, 8'h70, K1, 4'hF);
    idle_chk_lock("R4", 1);

    unlock();
    xact("R11", 1, 8'h6C, K0, 4'hF);
    idle_chk_lock("R11", 1);
    xact("R11", 1, 8'h20, 32'h5555_AAAA, 4'hF);        // dropped
    xact("R11", 1, 8'h70, K1, 4'hF);
    idle_chk_lock("R11", 0);
    xact("R12", 1, 8'h6F, K0, 4'hF);                    // decodes as first key
    idle_chk_lock("R12", 1);

    for (int i = 0; i < 1500; i++) begin
      int sel;
      logic [7:0] a;
      logic [31:0] d;
      logic [3:0] be;
      bit we;
      sel = $urandom % 8;
      case (sel)
        0: a = {6'h1B, 2'(($urandom))};
        1: a = {6'h1C, 2'(($urandom))};
        2: a = {6'h12, 2'(($urandom))};
        3, 4: begin a = 8'($urandom % 8'h6C); end
        5: a = 8'h80 | 8'($urandom);
        default: a = 8'($urandom);
      endcase
      case ($urandom % 5)
        0: d = K0;
        1: d = K1;
        2: d = 32'h0;
        default: d = $urandom;
      endcase
      be = ($urandom % 2) ? 4'hF : 4'($urandom);
      we = ($urandom % 4) != 0;
      xact(we ? (is_prot(a) ? "R5" : "R6") : "R7", we, a, d, be);
    end

    @(negedge clk);
    bus_req_i = 1'b0;
    done = 1;
    summary();
    $finish;
  end
endmodule